// File: doc/BRIEF.md
# Serial flash instruction sequencer

This block runs one transaction on a quad-capable serial flash bus by stepping through a short program of 16-bit instructions held in an internal table. Software loads the table ahead of time. The table holds 16 programs of four 32-bit words, with two instructions in each word. A single write to the start register chooses a program and gives the number of data bytes. The engine then lowers chip select and works through the instructions one after another. An instruction can shift out a command byte, an address byte or a mode byte. It can also idle the bus for a number of dummy clocks, or move data between the flash and the block's byte queues. Each of these can run on one, two or four IO lines.

Write data is taken from a transmit byte queue and read data is placed in a receive byte queue. Software polls the busy output until it clears. With the small-write guard enabled, a write data phase does not begin until at least 16 bytes are waiting in the transmit queue. Padding bytes that remain in the queue when the program finishes are discarded.

Top module: `flash_seq_engine`

## Requirements
- R1: An instruction is 16 bits: opcode in [15:10], lane code in [9:8], operand in [7:0]. Table word w of a program holds instruction 2w in bits [15:0] and instruction 2w+1 in bits [31:16], and instructions run in index order.
- R2: Program n occupies table words 4n to 4n+3. The start register value has the program index in bits [27:24], with bits [31:28] ignored, and the data byte count in bits [15:0].
- R3: Lane code 0 uses one line, 1 uses two lines, 2 uses four lines. Bits go out MSB first, with one group per serial clock: the single line is IO0 for output and IO1 for input, two lines put the upper bit on IO1, and four lines put the nibble on IO[3:0]. The serial clock idles low and is high for one system clock per beat.
- R4: Opcodes 1, 2 and 4 (command, address, mode) shift out the operand byte with the used lines enabled as outputs.
- R5: Opcode 3 (dummy) produces a number of serial clocks equal to its operand, capped at 64, with all IO output enables low. An operand of 0 produces no clocks.
- R6: Opcode 7 (read) takes the byte count from the start register, samples that many bytes with the outputs released, and places them in the receive queue in arrival order. A count of 0 skips the phase.
- R7: Opcode 8 (write) shifts out count bytes from the transmit queue in push order. The transmit full flag is high when 16 bytes are queued.
- R8: With the small-write guard, a write data phase waits with chip select low and no serial clocks until at least 16 bytes are queued. Bytes left in the transmit queue are discarded when the program ends.
- R9: Opcode 0 and every undefined opcode end the program. If no such opcode is met, the program ends after its eighth instruction.
- R10: Busy is high from the cycle after the start write until the program has ended. Chip select stays low, without a gap, for the whole program and is high when idle. A start write while busy is ignored.
- R11: After reset, busy is low, chip select is high, the serial clock is low, all output enables are low, and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Instruction table word write strobe |
| tbl_addr | input | 6 | Table word index (program*4 + word) |
| tbl_wdata | input | 32 | Table word data |
| trig_we | input | 1 | Start register write strobe |
| trig_wdata | input | 32 | Program index [27:24] and byte count [15:0] |
| busy | output | 1 | Program in progress |
| tx_push | input | 1 | Push one byte into the transmit queue |
| tx_byte | input | 8 | Byte to push |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_byte | output | 8 | Head byte of the receive queue |
| rx_valid | output | 1 | Receive queue not empty |
| fl_sclk | output | 1 | Serial clock to flash |
| fl_cs_n | output | 1 | Active-low chip select |
| fl_io_out | output | 4 | IO line output values |
| fl_io_oe | output | 4 | IO line output enables |
| fl_io_in | input | 4 | IO line input values |

## Verification
On every cycle, the assertions check the following. Chip select is never low while the engine is idle. The serial clock and the output enables are quiet whenever busy is low. The output enable pattern is always one of the three lane widths or all low. Each serial clock high phase lasts exactly one cycle. No beat count above 64 reaches the shifter, and a start write while busy leaves the chosen program unchanged. Only the bench scenarios can show that the table packing, the bit order per lane width, the read byte assembly, the dummy cap and the end after eight instructions give the right beats on the bus. They also show that the write guard stalls and then releases, and that leftover padding never leaks into a later write.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam logic [5:0] OP_STOP  = 6'd0;
    localparam logic [5:0] OP_CMD   = 6'd1;
    localparam logic [5:0] OP_ADDR  = 6'd2;
    localparam logic [5:0] OP_DUMMY = 6'd3;
    localparam logic [5:0] OP_MODE  = 6'd4;
    localparam logic [5:0] OP_READ  = 6'd7;
    localparam logic [5:0] OP_WRITE = 6'd8;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] pad;
        logic [7:0] opr;
    } instr_t;

    typedef enum logic [1:0] {
        DIR_OUT  = 2'd0,
        DIR_IN   = 2'd1,
        DIR_NONE = 2'd2
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_DATA  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_END   = 3'd4
    } st_e;

    function automatic logic [3:0] lane_mask(input logic [1:0] pad);
        case (pad)
            2'd0:    lane_mask = 4'b0001;
            2'd1:    lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/fseq_table.sv
module fseq_table #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fseq_fifo.sv
module fseq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [LW-1:0] lvl;
    } fifo_t;

    fifo_t       st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic        do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        bump = (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.lvl == '0);
    assign full    = (32'(st_q.lvl) == DEPTH);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = bump(st_q.wr);
            if (do_pop)  st_d.rd = bump(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[st_q.wr] <= din;
    end

    assign dout  = mem_q[st_q.rd];
    assign level = st_q.lvl;

    // R7 / R6: the fill level never exceeds the storage
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.lvl) <= DEPTH);

    // R6: a pop request on an empty queue leaves the level at zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push && !flush) |=> empty);

endmodule

// File: rtl/fseq_shifter.sv
module fseq_shifter
    import fseq_pkg::*;
#(
    parameter int NB_W = 7,
    parameter int MAX_BEATS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  dir_e            dir,
    input  logic [1:0]      pad,
    input  logic [NB_W-1:0] nbeats,
    input  logic [7:0]      byte_in,
    input  logic [3:0]      io_in,
    output logic            done,
    output logic [7:0]      byte_out,
    output logic            sclk,
    output logic [3:0]      io_out,
    output logic [3:0]      io_oe
);

    typedef struct packed {
        logic            active;
        logic            phase;
        logic [NB_W-1:0] cnt;
        logic [7:0]      sr;
        dir_e            dir;
        logic [1:0]      pad;
        logic            done;
    } shf_t;

    shf_t       s_d, s_q;
    logic [7:0] shifted;
    logic [3:0] mask;
    logic [3:0] bits;

    always_comb begin
        case (s_q.pad)
            2'd0:    shifted = {s_q.sr[6:0], io_in[1]};
            2'd1:    shifted = {s_q.sr[5:0], io_in[1:0]};
            default: shifted = {s_q.sr[3:0], io_in};
        endcase
        case (s_q.pad)
            2'd0:    bits = {3'b000, s_q.sr[7]};
            2'd1:    bits = {2'b00, s_q.sr[7:6]};
            default: bits = s_q.sr[7:4];
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.phase  = 1'b0;
                s_d.cnt    = nbeats;
                s_d.sr     = byte_in;
                s_d.dir    = dir;
                s_d.pad    = pad;
            end
        end else if (!s_q.phase) begin
            s_d.phase = 1'b1;
        end else begin
            s_d.phase = 1'b0;
            s_d.sr    = shifted;
            s_d.cnt   = s_q.cnt - 1'b1;
            if (s_q.cnt == NB_W'(1)) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dir <= DIR_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask     = lane_mask(s_q.pad);
    assign io_oe    = (s_q.active && s_q.dir == DIR_OUT) ? mask : 4'b0000;
    assign io_out   = bits & io_oe;
    assign sclk     = s_q.active && s_q.phase;
    assign done     = s_q.done;
    assign byte_out = s_q.sr;

    // R5: no beat count of zero or above the dummy cap is accepted
    a_r5_beats_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !s_q.active) |-> (nbeats != '0 && 32'(nbeats) <= MAX_BEATS));

    // R3: each serial clock high phase lasts one system clock
    a_r3_sclk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
    import fseq_pkg::*;
#(
    parameter int SEQS        = 16,
    parameter int SEQ_WORDS   = 4,
    parameter int FIFO_DEPTH  = 16,
    parameter int CNT_W       = 16,
    parameter int MAX_DUMMY   = 64,
    parameter bit SMALL_WRITE = 1'b1,
    parameter int TX_MIN      = 16,
    localparam int SEQ_W      = $clog2(SEQS),
    localparam int TBL_AW     = $clog2(SEQS * SEQ_WORDS),
    localparam int IP_W       = $clog2(SEQ_WORDS * 2),
    localparam int LW         = $clog2(FIFO_DEPTH + 1),
    localparam int NB_W       = $clog2(MAX_DUMMY + 1),
    localparam int SEQ_LSB    = 24,
    localparam int TX_START   = SMALL_WRITE ? TX_MIN : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [31:0]       tbl_wdata,
    input  logic              trig_we,
    input  logic [31:0]       trig_wdata,
    output logic              busy,
    input  logic              tx_push,
    input  logic [7:0]        tx_byte,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    output logic              fl_sclk,
    output logic              fl_cs_n,
    output logic [3:0]        fl_io_out,
    output logic [3:0]        fl_io_oe,
    input  logic [3:0]        fl_io_in
);

    typedef struct packed {
        st_e              st;
        logic [SEQ_W-1:0] seq;
        logic [IP_W-1:0]  ip;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rem;
        logic             rd;
        logic             data;
        logic [1:0]       dpad;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [31:0]     tbl_word;
    instr_t          ins;
    logic            shf_start, shf_done, adv;
    dir_e            shf_dir;
    logic [1:0]      shf_pad;
    logic [NB_W-1:0] shf_nb;
    logic [7:0]      shf_byte, shf_rx;
    logic            tx_pop, tx_flush, tx_empty;
    logic [7:0]      tx_head;
    logic [LW-1:0]   tx_level;
    logic            rx_push, rx_full, rx_empty;
    logic [LW-1:0]   rx_level;
    logic            unused_sig;

    assign unused_sig = ^{trig_wdata[31:SEQ_LSB+SEQ_W], trig_wdata[SEQ_LSB-1:CNT_W], rx_level};

    function automatic logic [NB_W-1:0] beats_per_byte(input logic [1:0] pad);
        case (pad)
            2'd0:    beats_per_byte = NB_W'(8);
            2'd1:    beats_per_byte = NB_W'(4);
            default: beats_per_byte = NB_W'(2);
        endcase
    endfunction

    fseq_table #(.WORDS(SEQS * SEQ_WORDS), .AW(TBL_AW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr ({eng_q.seq, eng_q.ip[IP_W-1:1]}),
        .rdata (tbl_word)
    );

    assign ins = eng_q.ip[0] ? instr_t'(tbl_word[31:16]) : instr_t'(tbl_word[15:0]);

    fseq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (tx_byte),
        .pop   (tx_pop),
        .flush (tx_flush),
        .dout  (tx_head),
        .level (tx_level),
        .empty (tx_empty),
        .full  (tx_full)
    );

    fseq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (shf_rx),
        .pop   (rx_pop),
        .flush (1'b0),
        .dout  (rx_byte),
        .level (rx_level),
        .empty (rx_empty),
        .full  (rx_full)
    );

    fseq_shifter #(.NB_W(NB_W), .MAX_BEATS(MAX_DUMMY)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (shf_start),
        .dir      (shf_dir),
        .pad      (shf_pad),
        .nbeats   (shf_nb),
        .byte_in  (shf_byte),
        .io_in    (fl_io_in),
        .done     (shf_done),
        .byte_out (shf_rx),
        .sclk     (fl_sclk),
        .io_out   (fl_io_out),
        .io_oe    (fl_io_oe)
    );

    always_comb begin
        eng_d     = eng_q;
        shf_start = 1'b0;
        shf_dir   = DIR_NONE;
        shf_pad   = ins.pad;
        shf_nb    = beats_per_byte(ins.pad);
        shf_byte  = ins.opr;
        tx_pop    = 1'b0;
        tx_flush  = 1'b0;
        rx_push   = 1'b0;
        adv       = 1'b0;

        case (eng_q.st)
            ST_IDLE: begin
                if (trig_we) begin
                    eng_d.st  = ST_FETCH;
                    eng_d.seq = trig_wdata[SEQ_LSB +: SEQ_W];
                    eng_d.ip  = '0;
                    eng_d.cnt = trig_wdata[CNT_W-1:0];
                end
            end
            ST_FETCH: begin
                case (ins.op)
                    OP_CMD, OP_ADDR, OP_MODE: begin
                        shf_start  = 1'b1;
                        shf_dir    = DIR_OUT;
                        eng_d.data = 1'b0;
                        eng_d.st   = ST_WAIT;
                    end
                    OP_DUMMY: begin
                        if (ins.opr == 8'd0) begin
                            adv = 1'b1;
                        end else begin
                            shf_start  = 1'b1;
                            shf_dir    = DIR_NONE;
                            shf_nb     = (32'(ins.opr) > MAX_DUMMY) ? NB_W'(MAX_DUMMY)
                                                                   : NB_W'(ins.opr);
                            eng_d.data = 1'b0;
                            eng_d.st   = ST_WAIT;
                        end
                    end
                    OP_READ: begin
                        if (eng_q.cnt == '0) begin
                            adv = 1'b1;
                        end else begin
                            eng_d.st   = ST_DATA;
                            eng_d.rem  = eng_q.cnt;
                            eng_d.rd   = 1'b1;
                            eng_d.dpad = ins.pad;
                        end
                    end
                    OP_WRITE: begin
                        if (eng_q.cnt == '0) begin
                            adv = 1'b1;
                        end else if (32'(tx_level) >= TX_START) begin
                            eng_d.st   = ST_DATA;
                            eng_d.rem  = eng_q.cnt;
                            eng_d.rd   = 1'b0;
                            eng_d.dpad = ins.pad;
                        end
                    end
                    default: eng_d.st = ST_END;
                endcase
            end
            ST_DATA: begin
                shf_pad = eng_q.dpad;
                shf_nb  = beats_per_byte(eng_q.dpad);
                if (eng_q.rd) begin
                    if (!rx_full) begin
                        shf_start  = 1'b1;
                        shf_dir    = DIR_IN;
                        eng_d.data = 1'b1;
                        eng_d.st   = ST_WAIT;
                    end
                end else if (!tx_empty) begin
                    shf_start  = 1'b1;
                    shf_dir    = DIR_OUT;
                    shf_byte   = tx_head;
                    tx_pop     = 1'b1;
                    eng_d.data = 1'b1;
                    eng_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (shf_done) begin
                    if (eng_q.data) begin
                        rx_push = eng_q.rd;
                        if (eng_q.rem > CNT_W'(1)) begin
                            eng_d.rem = eng_q.rem - 1'b1;
                            eng_d.st  = ST_DATA;
                        end else begin
                            adv = 1'b1;
                        end
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            ST_END: begin
                tx_flush = 1'b1;
                eng_d.st = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase

        if (adv) begin
            if (eng_q.ip == IP_W'(SEQ_WORDS * 2 - 1)) begin
                eng_d.st = ST_END;
            end else begin
                eng_d.ip = eng_q.ip + 1'b1;
                eng_d.st = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy     = (eng_q.st != ST_IDLE);
    assign fl_cs_n  = (eng_q.st == ST_IDLE) || (eng_q.st == ST_END);
    assign rx_valid = !rx_empty;

    // R10: chip select is only low while the engine reports busy
    a_r10_cs_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_cs_n |-> busy);

    // R10: the bus is quiet when the engine is idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_sclk && fl_io_oe == 4'b0000));

    // R10: a start write during a program does not change the program
    a_r10_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_we) |=> $stable(eng_q.seq));

    // R3: output enables form one of the lane patterns or none
    a_r3_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({1'b0, fl_io_oe} + 5'd1));

    // R6: the shifter never finishes a read byte into a full receive queue
    a_r6_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

endmodule

// File: tb/sim_flash_seq_engine.sv
module sim_flash_seq_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        trig_we = 1'b0;
    logic [31:0] trig_wdata = '0;
    logic        busy;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        fl_sclk, fl_cs_n;
    logic [3:0]  fl_io_out, fl_io_oe;
    logic [3:0]  fl_io_in = '0;

    always #5 clk = ~clk;

    flash_seq_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .busy(busy),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out),
        .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // bus log written by the flash model
    logic [3:0] log_oe [2048];
    logic [3:0] log_out [2048];
    int nedge = 0;
    int cs_falls = 0;

    // expected values
    logic [3:0]  e_oe [2048];
    logic [3:0]  e_out [2048];
    int          e_n;
    logic [7:0]  e_rx [64];
    int          e_nrx;
    logic [15:0] prog [8];
    logic [7:0]  tx_q [16];

    function automatic logic [3:0] inval(input int k);
        inval = 4'((k * 13) ^ (k >> 2) ^ 5);
    endfunction

    always @(posedge fl_sclk or negedge fl_cs_n) begin
        if (fl_sclk && !fl_cs_n) begin
            if (nedge < 2048) begin
                log_oe[nedge]  = fl_io_oe;
                log_out[nedge] = fl_io_out;
            end
            fl_io_in <= inval(nedge);
            nedge = nedge + 1;
        end else if (!fl_sclk) begin
            nedge = 0;
            cs_falls = cs_falls + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 180000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] mk(input int op, input int pad, input int opr);
        mk = {6'(op), 2'(pad), 8'(opr)};
    endfunction

    task automatic add_beat(input logic [3:0] oe, input logic [3:0] val);
        e_oe[e_n]  = oe;
        e_out[e_n] = val;
        e_n++;
    endtask

    task automatic add_out_byte(input logic [7:0] b, input int lanes, input logic [3:0] m);
        for (int j = 0; j < 8 / lanes; j++) begin
            add_beat(m, 4'(b >> (8 - lanes * (j + 1))) & m);
        end
    endtask

    task automatic build_exp(input int cnt);
        int wi;
        e_n = 0;
        e_nrx = 0;
        wi = 0;
        for (int i = 0; i < 8; i++) begin
            int op, pad, opr, lanes;
            logic [3:0] m;
            op = int'(prog[i][15:10]);
            pad = int'(prog[i][9:8]);
            opr = int'(prog[i][7:0]);
            lanes = (pad == 0) ? 1 : (pad == 1) ? 2 : 4;
            m = (pad == 0) ? 4'h1 : (pad == 1) ? 4'h3 : 4'hF;
            if (op == 1 || op == 2 || op == 4) begin
                add_out_byte(8'(opr), lanes, m);
            end else if (op == 3) begin
                for (int j = 0; j < ((opr > 64) ? 64 : opr); j++) add_beat(4'h0, 4'h0);
            end else if (op == 7) begin
                for (int b = 0; b < cnt; b++) begin
                    logic [7:0] v;
                    v = '0;
                    for (int j = 0; j < 8 / lanes; j++) begin
                        logic [3:0] s;
                        s = inval(e_n);
                        if (lanes == 1) v = {v[6:0], s[1]};
                        else if (lanes == 2) v = {v[5:0], s[1:0]};
                        else v = {v[3:0], s};
                        add_beat(4'h0, 4'h0);
                    end
                    e_rx[e_nrx] = v;
                    e_nrx++;
                end
            end else if (op == 8) begin
                for (int b = 0; b < cnt; b++) begin
                    add_out_byte(tx_q[wi], lanes, m);
                    wi++;
                end
            end else begin
                break;
            end
        end
    endtask

    task automatic load_prog(input int s);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_addr = 6'(s * 4 + w);
            tbl_wdata = {prog[2 * w + 1], prog[2 * w]};
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_push = 1'b1;
            tx_byte = tx_q[i];
        end
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic trigger(input logic [7:0] idx, input int cnt);
        @(negedge clk);
        trig_we = 1'b1;
        trig_wdata = {idx, 8'h00, 16'(cnt)};
        @(negedge clk);
        trig_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_log(input string tag);
        int first;
        int nbad;
        chk(nedge == e_n, tag, "sclk beats", nedge, e_n);
        first = -1;
        for (int k = 0; k < e_n && k < nedge; k++) begin
            if (first < 0 && (log_oe[k] != e_oe[k] || (log_out[k] & log_oe[k]) != e_out[k]))
                first = k;
        end
        chk(first < 0, tag, "beat content at first bad beat",
            (first < 0) ? 0 : int'({log_oe[first], log_out[first]}),
            (first < 0) ? 0 : int'({e_oe[first], e_out[first]}));
        chk(cs_falls == 1, tag, "cs low periods", cs_falls, 1);
        nbad = 0;
        for (int b = 0; b < e_nrx; b++) begin
            @(negedge clk);
            if (!rx_valid || rx_byte != e_rx[b]) begin
                if (nbad == 0)
                    chk(1'b0, tag, "rx byte", int'(rx_byte), int'(e_rx[b]));
                nbad++;
            end
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        if (e_nrx > 0 && nbad == 0) chk(1'b1, tag, "rx bytes", 0, 0);
        chk(!rx_valid, tag, "rx queue drained", int'(rx_valid), 0);
    endtask

    task automatic run_txn(input logic [7:0] idx, input int cnt, input int ntx,
                           input string tag);
        build_exp(cnt);
        cs_falls = 0;
        if (ntx > 0) push_tx(ntx);
        trigger(idx, cnt);
        wait_idle();
        check_log(tag);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 8; i++) prog[i] = 16'h0000;
    endtask

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(!busy, "R11", "busy", int'(busy), 0);
        chk(fl_cs_n, "R11", "cs_n", int'(fl_cs_n), 1);
        chk(!fl_sclk && fl_io_oe == 4'h0, "R11", "sclk/oe", int'({fl_sclk, fl_io_oe}), 0);
        chk(!rx_valid && !tx_full, "R11", "queues empty", int'({rx_valid, tx_full}), 0);

        // R1 R4 R3: command on one line then address on four, packed low half first
        clear_prog();
        prog[0] = mk(1, 0, 8'h9F);
        prog[1] = mk(2, 2, 8'hA5);
        prog[2] = mk(4, 1, 8'h6C);
        prog[3] = mk(0, 0, 0);
        load_prog(5);
        clear_prog();
        prog[0] = mk(1, 2, 8'h11);
        load_prog(6);
        clear_prog();
        prog[0] = mk(1, 0, 8'h9F);
        prog[1] = mk(2, 2, 8'hA5);
        prog[2] = mk(4, 1, 8'h6C);
        run_txn(8'h05, 0, 0, "R1_R4");

        // R2: upper index bits ignored, program 5 selected by 0x15
        run_txn(8'h15, 0, 0, "R2");

        // R5: dummy capped at 64, zero gives none
        clear_prog();
        prog[0] = mk(3, 2, 70);
        prog[1] = mk(3, 0, 0);
        prog[2] = mk(3, 1, 5);
        prog[3] = mk(1, 0, 8'h3C);
        load_prog(4);
        run_txn(8'h04, 0, 0, "R5");

        // R6 R3: reads on each lane width, byte count from start register
        for (int p = 0; p < 3; p++) begin
            clear_prog();
            prog[0] = mk(1, 0, 8'h6B);
            prog[1] = mk(7, p, 0);
            load_prog(7);
            run_txn(8'h07, 3, 0, "R6_R3");
        end
        clear_prog();
        prog[0] = mk(7, 2, 0);
        prog[1] = mk(1, 0, 8'hE7);
        load_prog(7);
        run_txn(8'h07, 0, 0, "R6_zero");

        // R9: eight instructions without stop, next program holds commands
        for (int i = 0; i < 8; i++) prog[i] = mk(1, i % 3, 8'h30 + i);
        load_prog(3);
        load_prog(2);
        run_txn(8'h02, 0, 0, "R9_eight");
        clear_prog();
        prog[0] = mk(1, 0, 8'h05);
        prog[1] = mk(5, 0, 8'hFF);
        prog[2] = mk(1, 0, 8'hAA);
        load_prog(8);
        run_txn(8'h08, 0, 0, "R9_undef");

        // R8 R10: small write stalls, then releases; start while busy ignored
        clear_prog();
        prog[0] = mk(1, 0, 8'h02);
        prog[1] = mk(8, 2, 0);
        load_prog(1);
        for (int i = 0; i < 8; i++) tx_q[i] = 8'h50 + 8'(i * 3);
        for (int i = 8; i < 16; i++) tx_q[i] = 8'h00;
        build_exp(8);
        cs_falls = 0;
        push_tx(8);
        trigger(8'h01, 8);
        repeat (60) @(negedge clk);
        chk(busy && !fl_cs_n, "R8", "stalled with cs low", int'({busy, fl_cs_n}), 2);
        chk(nedge == 8, "R8", "beats before release", nedge, 8);
        trigger(8'h05, 3);
        for (int i = 8; i < 16; i++) begin
            @(negedge clk);
            tx_push = 1'b1;
            tx_byte = tx_q[i];
        end
        @(negedge clk);
        tx_push = 1'b0;
        wait_idle();
        check_log("R8_R10");
        repeat (20) @(negedge clk);
        chk(!busy && fl_cs_n && cs_falls == 1, "R10", "ignored start not run",
            int'({busy, fl_cs_n}), 1);

        // R7 R8: fresh bytes after leftovers discarded, full flag at 16
        for (int i = 0; i < 16; i++) tx_q[i] = 8'hC0 + 8'(i);
        clear_prog();
        prog[0] = mk(8, 1, 0);
        load_prog(9);
        build_exp(4);
        cs_falls = 0;
        push_tx(16);
        chk(tx_full, "R7", "tx full at 16", int'(tx_full), 1);
        trigger(8'h09, 4);
        wait_idle();
        check_log("R7_R8_flush");
        chk(!tx_full, "R8", "leftover discarded", int'(tx_full), 0);

        // random programs
        for (int t = 0; t < 30; t++) begin
            int s, cnt, nrd, nwr, ntx;
            s = int'($urandom % 16);
            cnt = int'($urandom % 9);
            nrd = 0;
            nwr = 0;
            ntx = 0;
            for (int i = 0; i < 8; i++) begin
                int sel, op, opr;
                sel = int'($urandom % 12);
                opr = int'($urandom % 256);
                case (sel)
                    0, 1, 2: op = 1;
                    3, 4:    op = 2;
                    5:       op = 4;
                    6, 7:    begin op = 3; opr = int'($urandom % 80); end
                    8, 9:    op = (nrd == 0) ? 7 : 1;
                    10:      op = (nwr == 0) ? 8 : 2;
                    default: op = ($urandom % 3 == 0) ? 0 : 4;
                endcase
                if (op == 7) nrd++;
                if (op == 8) nwr++;
                prog[i] = mk(op, int'($urandom % 3), opr);
            end
            for (int i = 0; i < 16; i++) tx_q[i] = 8'($urandom);
            for (int i = 0; i < 8; i++) begin
                if (prog[i][15:10] == 6'd0) break;
                if (prog[i][15:10] == 6'd8 && cnt > 0) ntx = 16;
            end
            load_prog(s);
            run_txn(8'(s) | 8'(($urandom % 16) << 4), cnt, ntx, "R1_R3_R6_R7_rand");
            if (tx_full) chk(1'b0, "R8", "random leftover", 1, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule